// File: doc/BRIEF.md
# Two-Mode ADC Input Sequencer

This block steps the input multiplexer in front of a single shared delta-sigma converter through a fixed cycle of six slots, one slot per conversion. For each slot it drives a 3-bit code that selects one of eight analog sources: six phase-current pins, a neutral-current pin and an on-chip temperature sensor. The converter raises a one-clock strobe at the end of each conversion, and the sequencer then moves to the next slot.

A mode input picks one of two sequences. The regular sequence samples all six phase currents. The alternate sequence puts the temperature sensor in the slot that normally holds phase 0 and the neutral current in the slot that normally holds phase 2. Those two phases therefore go unsampled while the alternate sequence runs. The mode input is captured only when a cycle starts, so one cycle never mixes the two sequences.

The block also reports the active slot number and gives a one-clock pulse when a new cycle begins, so downstream logic can tag each sample with its source. An enable input freezes the sequencer in place.

Top module: `adc_input_sequencer`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block moves to slot 0 in regular mode, with `src_sel` = 0, `alt_active` = 0 and `cycle_start` = 0 from the next cycle on.
- R2: When `enable` and `conv_done` are both high at a clock edge and the slot is below 5, `slot_idx` goes up by exactly one on that edge.
- R3: When `enable` and `conv_done` are both high at a clock edge with `slot_idx` = 5, `slot_idx` wraps to 0.
- R4: In regular mode (`alt_active` = 0), slots 0 to 5 select codes 0 to 5, which are phase inputs I0 to I5 in that order.
- R5: In alternate mode (`alt_active` = 1), slots 0 to 5 select codes 7, 1, 6, 3, 4, 5. Code 6 is the neutral input and code 7 is the temperature sensor.
- R6: `alt_active` takes the value of `alt_mode_req` only on an edge where the slot wraps from 5 to 0. At every other edge it holds, whatever `alt_mode_req` does.
- R7: `cycle_start` is high for exactly the one cycle that follows a wrap from 5 to 0. It is low in every other cycle, including the cycles after reset.
- R8: While `enable` is low, `conv_done` is ignored: `slot_idx`, `src_sel` and `alt_active` hold their values and `cycle_start` stays low.
- R9: While `alt_active` is high, `src_sel` never shows code 0 (I0) or code 2 (I2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | High lets the sequencer advance; low freezes it |
| conv_done | input | 1 | One-clock strobe marking the end of a conversion |
| alt_mode_req | input | 1 | Requested sequence: 1 = alternate, 0 = regular; captured at cycle start |
| src_sel | output | 3 | Source select code: 0-5 = I0-I5, 6 = neutral, 7 = temperature |
| slot_idx | output | 3 | Active slot number, 0 to 5 |
| cycle_start | output | 1 | One-clock pulse in the first cycle of a new sequence |
| alt_active | output | 1 | Sequence in force: 1 = alternate, 0 = regular |

## Verification
The wrap from slot 5 to slot 0 and the capture of the mode request happen on the same edge. The bench flips `alt_mode_req` in the same cycle as the strobe that ends slot 5, in both directions. It judges the result by whether the first new cycle already shows the new sequence on `src_sel`, with `cycle_start` high. As a contrast case, a mode change requested in the middle of a cycle must leave the rest of that cycle on the old sequence. A freeze case holds `enable` low while a strobe arrives at slot 5, and there neither the wrap nor the mode capture may happen.

// File: rtl/adc_seq_pkg.sv
// adc_seq_pkg
// Shared source-select encoding for the ADC input sequencer.
// Assumes a 3-bit select bus with eight sources: six phase-current
// pins, a neutral-current pin and an internal temperature sensor.
package adc_seq_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_I0   = 3'd0,
        SRC_I1   = 3'd1,
        SRC_I2   = 3'd2,
        SRC_I3   = 3'd3,
        SRC_I4   = 3'd4,
        SRC_I5   = 3'd5,
        SRC_NEUT = 3'd6,
        SRC_TEMP = 3'd7
    } src_code_e;

endpackage

// File: rtl/seq_slot_counter.sv
// seq_slot_counter
// Counts conversion slots 0..NUM_SLOTS-1. It advances on each qualified
// conversion strobe, captures the requested mode at each wrap and flags
// the first cycle of every new sequence.
// Assumes conv_done is synchronous to clk and lasts one clock per conversion.
module seq_slot_counter #(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              conv_done,
    input  logic              alt_req,
    output logic [SLOT_W-1:0] slot,
    output logic              alt_mode,
    output logic              cyc_start
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic step;
    logic wrap;

    // Qualify the strobe with the enable, and detect the end of a cycle.
    always_comb begin
        step = enable && conv_done;
        wrap = step && (slot == LAST_SLOT);
    end

    // Slot counter, mode capture at the wrap and cycle-start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= '0;
            alt_mode  <= 1'b0;
            cyc_start <= 1'b0;
        end else begin
            cyc_start <= wrap;
            if (wrap) begin
                slot     <= '0;
                alt_mode <= alt_req;
            end else if (step) begin
                slot <= slot + 1'b1;
            end
        end
    end

    // Marks cycles after the first edge out of reset, for $past-based checks.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && slot != LAST_SLOT) |=> (slot == $past(slot) + 1'b1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && slot == LAST_SLOT) |=> (slot == '0));

    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST_SLOT);

    p_mode_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && alt_mode != $past(alt_mode)) |-> $past(wrap));

    p_start_slot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (slot == '0));

    p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(slot) && $stable(alt_mode) && !cyc_start));

endmodule

// File: rtl/seq_source_map.sv
// seq_source_map
// Turns slot number and sequence mode into a source-select code.
// The regular table is the identity on the slot number. The alternate
// table puts the temperature sensor in slot 0 and the neutral input in
// slot 2. It is purely combinational.
// Assumes slot stays below NUM_SLOTS; any slot out of range maps to I0.
module seq_source_map
    import adc_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int TEMP_SLOT = 0,
    parameter int NEUT_SLOT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic              alt_mode,
    output src_code_e         src
);

    src_code_e reg_tab [NUM_SLOTS];
    src_code_e alt_tab [NUM_SLOTS];

    // One table entry per slot for each of the two sequences.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign reg_tab[g] = src_code_e'(SEL_W'(g));
        if (g == TEMP_SLOT) begin : g_temp
            assign alt_tab[g] = SRC_TEMP;
        end else if (g == NEUT_SLOT) begin : g_neut
            assign alt_tab[g] = SRC_NEUT;
        end else begin : g_same
            assign alt_tab[g] = src_code_e'(SEL_W'(g));
        end
    end

    // Pick the entry for the active slot from the table in force.
    always_comb begin
        if (int'(slot) >= NUM_SLOTS) src = SRC_I0;
        else if (alt_mode)           src = alt_tab[slot];
        else                         src = reg_tab[slot];
    end

    p_regular_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_mode && int'(slot) < NUM_SLOTS) |-> (int'(src) == int'(slot)));

    p_alt_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_mode && int'(slot) == TEMP_SLOT) |-> (src == SRC_TEMP));

    p_alt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alt_mode |-> (src != SRC_I0 && src != SRC_I2));

endmodule

// File: rtl/adc_input_sequencer.sv
// adc_input_sequencer
// Top level of the two-mode ADC input sequencer. It drives the analog
// multiplexer select for a shared converter through a six-slot cycle,
// in either the regular or the alternate sequence.
// Assumes a synchronous active-low reset and a one-clock conversion strobe.
module adc_input_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              conv_done,
    input  logic              alt_mode_req,
    output logic [SEL_W-1:0]  src_sel,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              cycle_start,
    output logic              alt_active
);

    src_code_e src_code;

    seq_slot_counter #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .conv_done (conv_done),
        .alt_req   (alt_mode_req),
        .slot      (slot_idx),
        .alt_mode  (alt_active),
        .cyc_start (cycle_start)
    );

    seq_source_map #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot_idx),
        .alt_mode (alt_active),
        .src      (src_code)
    );

    // Present the enum code on the plain output bus.
    always_comb src_sel = src_code;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (slot_idx == '0 && src_sel == '0 && !alt_active && !cycle_start));

endmodule

// File: tb/adc_input_sequencer_bench.sv
// adc_input_sequencer_bench
// Directed bench: one task per scenario, each checking its own results
// against a model built from the requirements.
module adc_input_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       conv_done = 1'b0;
    logic       alt_mode_req = 1'b0;
    logic [2:0] src_sel;
    logic [2:0] slot_idx;
    logic       cycle_start;
    logic       alt_active;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Expected state of the model.
    int exp_slot = 0;
    bit exp_alt  = 0;
    bit exp_cs   = 0;

    always #2.5 clk = ~clk;

    adc_input_sequencer u_adc_input_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .conv_done    (conv_done),
        .alt_mode_req (alt_mode_req),
        .src_sel      (src_sel),
        .slot_idx     (slot_idx),
        .cycle_start  (cycle_start),
        .alt_active   (alt_active)
    );

    function automatic int exp_src(input int s, input bit a);
        if (a && s == 0) return 7;
        if (a && s == 2) return 6;
        return s;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the model; src_tag names the mapping requirement.
    task automatic chk_all(input string req, input string src_tag);
        chk(req, "slot_idx", int'(slot_idx), exp_slot);
        chk(req, "alt_active", int'(alt_active), int'(exp_alt));
        chk("R7", "cycle_start", int'(cycle_start), int'(exp_cs));
        chk(src_tag, "src_sel", int'(src_sel), exp_src(exp_slot, exp_alt));
        if (alt_active) begin
            checks++;
            if (src_sel == 3'd0 || src_sel == 3'd2) begin
                errors++;
                $display("FAIL R9 src_sel in alternate: actual=%0d expected=not 0 or 2", src_sel);
            end
        end
    endtask

    // Apply one clock of stimulus and update the model.
    task automatic tick(input bit en, input bit done, input bit req);
        @(negedge clk);
        enable = en; conv_done = done; alt_mode_req = req;
        @(posedge clk);
        #1;
        if (en && done) begin
            if (exp_slot == 5) begin
                exp_slot = 0; exp_alt = req; exp_cs = 1;
            end else begin
                exp_slot++; exp_cs = 0;
            end
        end else begin
            exp_cs = 0;
        end
        conv_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b1; conv_done = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        exp_slot = 0; exp_alt = 0; exp_cs = 0;
        chk_all("R1", "R1");
        @(negedge clk);
        rst_n = 1'b1; conv_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        tick(1, 0, 0);
        chk_all("R1", "R4");
    endtask

    task automatic t_regular();
        for (int i = 0; i < 6; i++) begin
            tick(1, 1, 0);
            chk_all((i == 5) ? "R3" : "R2", "R4");
            tick(1, 0, 0);
            chk_all("R2", "R4");
        end
    endtask

    task automatic t_mid_cycle_request();
        tick(1, 1, 0);
        tick(1, 1, 1);
        chk_all("R6", "R4");
        for (int i = 0; i < 3; i++) begin
            tick(1, 1, 1);
            chk_all("R6", "R4");
        end
        tick(1, 1, 1);
        chk_all("R6", "R5");
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 6; i++) begin
            tick(1, 1, 1);
            chk_all((i == 5) ? "R3" : "R2", "R5");
        end
    endtask

    task automatic t_wrap_flip();
        for (int i = 0; i < 5; i++) tick(1, 1, 1);
        chk_all("R6", "R5");
        tick(1, 1, 0);
        chk_all("R6", "R4");
        for (int i = 0; i < 5; i++) tick(1, 1, 0);
        tick(1, 1, 1);
        chk_all("R6", "R5");
    endtask

    task automatic t_freeze();
        for (int i = 0; i < 5; i++) tick(1, 1, 1);
        chk_all("R8", "R5");
        for (int i = 0; i < 4; i++) begin
            tick(0, 1, 0);
            chk_all("R8", "R5");
        end
        tick(1, 1, 0);
        chk_all("R3", "R4");
        tick(1, 1, 0);
        tick(1, 1, 0);
        for (int i = 0; i < 3; i++) begin
            tick(0, 1, 1);
            chk_all("R8", "R4");
        end
    endtask

    task automatic t_reset_in_alt();
        for (int i = 0; i < 4; i++) tick(1, 1, 1);
        tick(1, 1, 1);
        tick(1, 1, 1);
        tick(1, 1, 1);
        do_reset();
        tick(1, 0, 1);
        chk_all("R1", "R4");
    endtask

    initial begin
        t_reset();
        t_regular();
        t_mid_cycle_request();
        t_alternate();
        t_wrap_flip();
        t_freeze();
        t_reset_in_alt();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule